// File: doc/BRIEF.md
# Folding Address Translator

This block turns a CPU address into an offset within a packed physical store. The store holds three parts back to back: a ROM, a low RAM area and a high area. Only the low 24 bits of the address matter. Addresses below 1 MB repeat every ROM size. Addresses from 1 MB up to a configurable low limit land directly after the ROM. Addresses at or above a configurable high boundary land after the low area. Between the low limit and the high boundary lies a hole, and an access there raises a fault.

Inside the high area, each of the two topmost 4 KB windows holds only 1 KB. That 1 KB repeats four times across its window, and the repeat is applied before the high boundary is subtracted. Three run-time fields set the layout: the ROM size as a power of two, the low limit and the high boundary. A write that asks for a low limit under 1 MB is dropped, and the old layout stays. Each request gives a registered result (valid, fault, offset) on the next clock edge.

Top module: `addr_fold_top`

## Requirements
- R1: Bits 31 to 24 of `req_addr` have no effect on the result.
- R2: `rsp_valid` equals `req_valid` one clock edge later. With no request, `rsp_fault` and `rsp_off` are 0.
- R3: For an effective address a < 0x100000, the offset is a AND (2^rom_log2 − 1), with no fault.
- R4: For 0x100000 ≤ a < low_end, the offset is a − 0x100000 + 2^rom_log2, with no fault.
- R5: For a ≥ high_start (and a ≥ low_end), the offset is (f − high_start + 2^rom_log2 + low_end − 0x100000) modulo 2^25. Here f is a after the window fold of R6.
- R6: The fold is f = a AND 0xFFF3FF when a ≥ 0xFFF000, f = a AND 0xFFE3FF when 0xFFE000 ≤ a < 0xFFF000, and f = a otherwise.
- R7: For low_end ≤ a < high_start with a ≥ 0x100000, `rsp_fault` is 1 and `rsp_off` is 0.
- R8: A configuration write with `cfg_low_end` < 0x100000 changes none of the three layout fields.
- R9: After reset, the outputs are 0 and the layout is rom_log2 = 18, low_end = 0x200000, high_start = 0xFFC000.
- R10: A request presented in the same cycle as an accepted configuration write is translated with the old layout. Later requests use the new layout.
- R11: The regions are tested in this order: ROM area, then low area, then high area. A low area that overlaps high_start takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is present this cycle |
| req_addr | input | 32 | CPU address (only bits 23:0 are used) |
| cfg_wr | input | 1 | Layout write strobe |
| cfg_rom_log2 | input | 5 | New ROM size as log2 of bytes |
| cfg_low_end | input | 24 | New low limit (exclusive) |
| cfg_high_start | input | 24 | New high boundary (inclusive) |
| rsp_valid | output | 1 | Registered result is valid |
| rsp_fault | output | 1 | Registered hole fault |
| rsp_off | output | 25 | Registered physical offset |

## Verification
Every result is due exactly one edge after its request is sampled. A layout write becomes visible to requests sampled on the edge after the write edge. The bench reference model runs on each rising edge, using the inputs and its own copy of the layout as they stood before that edge, and then applies any write it accepts. Outputs are compared at the next falling edge, half a period after the design's register has updated. The same-cycle write-plus-request case therefore checks R10 with no timing slack either way.

// File: rtl/addr_fold_pkg.sv
package addr_fold_pkg;

    localparam int ADDR_W          = 32;
    localparam int EFF_W           = 24;
    localparam int PHYS_W          = EFF_W + 1;
    localparam int LOG2_W          = 5;
    localparam int LOW_REGION_LOG2 = 20;
    localparam int WIN_NUM         = 2;
    localparam int WIN_SPAN_LOG2   = 12;
    localparam int WIN_KEEP_LOG2   = 10;

    localparam logic [EFF_W-1:0] LOW_BASE = EFF_W'(1) << LOW_REGION_LOG2;

    typedef struct packed {
        logic [LOG2_W-1:0] rom_log2;
        logic [EFF_W-1:0]  low_end;
        logic [EFF_W-1:0]  high_start;
    } fold_cfg_t;

    typedef enum logic [1:0] {
        RGN_ROM,
        RGN_LOW,
        RGN_HIGH,
        RGN_HOLE
    } rgn_e;

    function automatic logic [PHYS_W-1:0] rom_span(input logic [LOG2_W-1:0] lg);
        return PHYS_W'(1) << lg;
    endfunction

    // Window idx starts (idx+1) spans below the top of the effective space.
    function automatic logic [EFF_W-1:0] win_base(input int idx);
        return EFF_W'((1 << EFF_W) - ((idx + 1) << WIN_SPAN_LOG2));
    endfunction

    function automatic logic [EFF_W-1:0] win_mask(input int idx);
        return win_base(idx) | EFF_W'((1 << WIN_KEEP_LOG2) - 1);
    endfunction

endpackage

// File: rtl/addr_fold_cfg.sv
module addr_fold_cfg
    import addr_fold_pkg::*;
#(
    parameter fold_cfg_t RST_CFG = '0
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      wr,
    input  fold_cfg_t wr_cfg,
    output fold_cfg_t cur
);

    logic accept;

    // A low limit under the ROM area is refused; the whole layout is kept.
    assign accept = wr && (wr_cfg.low_end >= LOW_BASE);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= RST_CFG;
        end else if (accept) begin
            cur <= wr_cfg;
        end
    end

endmodule

// File: rtl/addr_fold_region.sv
module addr_fold_region
    import addr_fold_pkg::*;
(
    input  logic [EFF_W-1:0] addr,
    input  fold_cfg_t        cfg,
    output rgn_e             rgn
);

    // Ordered tests: ROM area, then low area, then high area (R11).
    always_comb begin
        if (addr < LOW_BASE) begin
            rgn = RGN_ROM;
        end else if (addr < cfg.low_end) begin
            rgn = RGN_LOW;
        end else if (addr >= cfg.high_start) begin
            rgn = RGN_HIGH;
        end else begin
            rgn = RGN_HOLE;
        end
    end

endmodule

// File: rtl/addr_fold_offset.sv
module addr_fold_offset
    import addr_fold_pkg::*;
(
    input  logic [EFF_W-1:0]  addr,
    input  fold_cfg_t         cfg,
    input  rgn_e              rgn,
    output logic [PHYS_W-1:0] off
);

    logic [WIN_NUM-1:0]  win_hit;
    logic [EFF_W-1:0]    win_val [WIN_NUM];
    logic [EFF_W-1:0]    folded;
    logic [PHYS_W-1:0]   rom_sz;
    logic [PHYS_W-1:0]   high_base;

    generate
        for (genvar gi = 0; gi < WIN_NUM; gi++) begin : g_win
            assign win_hit[gi] = (addr >= win_base(gi));
            assign win_val[gi] = addr & win_mask(gi);
        end
    endgenerate

    // Lower index is the higher window and wins when several compare true.
    always_comb begin
        folded = addr;
        for (int k = WIN_NUM - 1; k >= 0; k--) begin
            if (win_hit[k]) begin
                folded = win_val[k];
            end
        end
    end

    assign rom_sz    = rom_span(cfg.rom_log2);
    assign high_base = rom_sz + PHYS_W'(cfg.low_end) - PHYS_W'(LOW_BASE);

    always_comb begin
        unique case (rgn)
            RGN_ROM:  off = PHYS_W'(addr) & (rom_sz - PHYS_W'(1));
            RGN_LOW:  off = PHYS_W'(addr) - PHYS_W'(LOW_BASE) + rom_sz;
            RGN_HIGH: off = PHYS_W'(folded) - PHYS_W'(cfg.high_start) + high_base;
            default:  off = '0;
        endcase
    end

endmodule

// File: rtl/addr_fold_top.sv
module addr_fold_top
    import addr_fold_pkg::*;
#(
    parameter logic [LOG2_W-1:0] RST_ROM_LOG2   = LOG2_W'(18),
    parameter logic [EFF_W-1:0]  RST_LOW_END    = 24'h200000,
    parameter logic [EFF_W-1:0]  RST_HIGH_START = 24'hFFC000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              cfg_wr,
    input  logic [LOG2_W-1:0] cfg_rom_log2,
    input  logic [EFF_W-1:0]  cfg_low_end,
    input  logic [EFF_W-1:0]  cfg_high_start,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [PHYS_W-1:0] rsp_off
);

    localparam fold_cfg_t RST_CFG = '{
        rom_log2:   RST_ROM_LOG2,
        low_end:    RST_LOW_END,
        high_start: RST_HIGH_START
    };

    logic [EFF_W-1:0]  eff_addr;
    logic              unused_upper;
    fold_cfg_t         wr_cfg;
    fold_cfg_t         cfg_cur;
    rgn_e              rgn;
    logic [PHYS_W-1:0] comb_off;

    assign eff_addr     = req_addr[EFF_W-1:0];
    assign unused_upper = ^req_addr[ADDR_W-1:EFF_W];

    assign wr_cfg = '{
        rom_log2:   cfg_rom_log2,
        low_end:    cfg_low_end,
        high_start: cfg_high_start
    };

    addr_fold_cfg #(
        .RST_CFG (RST_CFG)
    ) u_cfg (
        .clk    (clk),
        .rst    (rst),
        .wr     (cfg_wr),
        .wr_cfg (wr_cfg),
        .cur    (cfg_cur)
    );

    addr_fold_region u_region (
        .addr (eff_addr),
        .cfg  (cfg_cur),
        .rgn  (rgn)
    );

    addr_fold_offset u_offset (
        .addr (eff_addr),
        .cfg  (cfg_cur),
        .rgn  (rgn),
        .off  (comb_off)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_off   <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_fault <= req_valid && (rgn == RGN_HOLE);
            rsp_off   <= (req_valid && (rgn != RGN_HOLE)) ? comb_off : '0;
        end
    end

endmodule

// File: rtl/addr_fold_chk.sv
module addr_fold_chk
    import addr_fold_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [EFF_W-1:0]  req_a24,
    input logic              cfg_wr,
    input logic [EFF_W-1:0]  cfg_low_end,
    input fold_cfg_t         cur_cfg,
    input logic              rsp_valid,
    input logic              rsp_fault,
    input logic [PHYS_W-1:0] rsp_off
);

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_valid && !rsp_fault && rsp_off == '0));

    assert_fault_zero_off_R7: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> (rsp_off == '0 && rsp_valid));

    assert_hole_faults_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_a24 >= LOW_BASE && req_a24 >= cur_cfg.low_end
         && req_a24 < cur_cfg.high_start) |=> rsp_fault);

    assert_reject_keeps_R8: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_low_end < LOW_BASE) |=> $stable(cur_cfg));

    assert_rom_in_range_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_a24 < LOW_BASE) |=>
        (!rsp_fault && rsp_off < rom_span($past(cur_cfg.rom_log2))));

endmodule

bind addr_fold_top addr_fold_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_a24     (req_addr[23:0]),
    .cfg_wr      (cfg_wr),
    .cfg_low_end (cfg_low_end),
    .cur_cfg     (cfg_cur),
    .rsp_valid   (rsp_valid),
    .rsp_fault   (rsp_fault),
    .rsp_off     (rsp_off)
);

// File: tb/addr_fold_top_bench.sv
`timescale 1ns/1ps
module addr_fold_top_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        cfg_wr = 1'b0;
    logic [4:0]  cfg_rom_log2 = '0;
    logic [23:0] cfg_low_end = '0;
    logic [23:0] cfg_high_start = '0;
    logic        rsp_valid;
    logic        rsp_fault;
    logic [24:0] rsp_off;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;
    bit started = 0;
    string phase = "R9";

    // Reference model state
    longint m_log2, m_le, m_hs;
    logic        exp_v, exp_f;
    logic [24:0] exp_o;
    string       exp_tag, exp_phase;

    always #4 clk = ~clk;

    addr_fold_top u_addr_fold_top (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .cfg_wr(cfg_wr), .cfg_rom_log2(cfg_rom_log2), .cfg_low_end(cfg_low_end),
        .cfg_high_start(cfg_high_start), .rsp_valid(rsp_valid),
        .rsp_fault(rsp_fault), .rsp_off(rsp_off)
    );

    task automatic model(input logic [31:0] addr, output logic f,
                         output logic [24:0] o, output string tag);
        longint a, rom, m, r;
        a   = longint'(addr) & 64'hFFFFFF;
        rom = longint'(1) << m_log2;
        f   = 1'b0;
        r   = 0;
        if (a < 64'h100000) begin
            r = a & (rom - 1); tag = "R3";
        end else if (a < m_le) begin
            r = a - 64'h100000 + rom; tag = "R4";
        end else if (a >= m_hs) begin
            m = a; tag = "R5";
            if (a >= 64'hFFF000) begin m = a & 64'hFFF3FF; tag = "R6"; end
            else if (a >= 64'hFFE000) begin m = a & 64'hFFE3FF; tag = "R6"; end
            r = m - m_hs + rom + m_le - 64'h100000;
        end else begin
            f = 1'b1; tag = "R7";
        end
        o = 25'(r & 64'h1FFFFFF);
    endtask

    always @(posedge clk) begin
        cycles++;
        exp_phase = phase;
        if (rst) begin
            m_log2 = 18; m_le = 64'h200000; m_hs = 64'hFFC000;
            exp_v = 0; exp_f = 0; exp_o = '0; exp_tag = "R9";
        end else begin
            exp_v = req_valid;
            if (req_valid) model(req_addr, exp_f, exp_o, exp_tag);
            else begin exp_f = 0; exp_o = '0; exp_tag = "R2"; end
            if (cfg_wr && cfg_low_end >= 24'h100000) begin
                m_log2 = longint'(cfg_rom_log2);
                m_le   = longint'(cfg_low_end);
                m_hs   = longint'(cfg_high_start);
            end
        end
        started = 1;
    end

    always @(negedge clk) begin
        if (started && !done) begin
            checks++;
            if (rsp_valid !== exp_v || rsp_fault !== exp_f || rsp_off !== exp_o) begin
                errors++;
                $display("FAIL %s/%s got v=%0b f=%0b off=%h exp v=%0b f=%0b off=%h",
                         exp_phase, exp_tag, rsp_valid, rsp_fault, rsp_off,
                         exp_v, exp_f, exp_o);
            end
        end
    end

    task automatic finish_run();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cycles > 100000 && !done) begin
            errors++;
            $display("FAIL watchdog expired after %0d cycles, expected completion", cycles);
            finish_run();
        end
    end

    task automatic req(input logic [31:0] a);
        @(negedge clk);
        req_valid = 1; req_addr = a; cfg_wr = 0;
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 0; cfg_wr = 0;
    endtask

    task automatic cfg(input logic [4:0] lg, input logic [23:0] le,
                       input logic [23:0] hs, input bit with_req,
                       input logic [31:0] a);
        @(negedge clk);
        cfg_wr = 1; cfg_rom_log2 = lg; cfg_low_end = le; cfg_high_start = hs;
        req_valid = with_req; req_addr = a;
    endtask

    initial begin
        // R9: reset state and default layout
        repeat (3) @(negedge clk);
        rst = 0;
        phase = "R9";
        req(32'h0000_0123); req(32'h0004_51AB); req(32'h000F_FFFF);
        // R1: upper address bits ignored
        phase = "R1";
        req(32'hAB04_51AB); req(32'hFF1F_FFFF); req(32'h01FF_E7FF);
        // R4 / R7: low area and hole edges
        phase = "R4";
        req(32'h0010_0000); req(32'h001F_FFFF); req(32'h0020_0000);
        phase = "R7";
        req(32'h0080_0000); req(32'h00FF_BFFF);
        // R5 / R6: high area and folded windows
        phase = "R5";
        req(32'h00FF_C000); req(32'h00FF_DFFF);
        phase = "R6";
        req(32'h00FF_E000); req(32'h00FF_E7FF); req(32'h00FF_EFFF);
        req(32'h00FF_F000); req(32'h00FF_F400); req(32'h00FF_FFFF);
        // R2: idle gap
        phase = "R2";
        idle(); idle(); req(32'h0000_0010); idle();
        // R8: rejected write keeps every field
        phase = "R8";
        cfg(5'd12, 24'h0F_FFFF, 24'h80_0000, 0, '0);
        req(32'h001F_FFFF); req(32'h0005_0000); req(32'h0080_0000); req(32'h00FF_C000);
        // R10: request in the write cycle uses the old layout
        phase = "R10";
        cfg(5'd16, 24'h30_0000, 24'hF0_0000, 1, 32'h0025_0000);
        req(32'h0025_0000); req(32'h0001_2345); req(32'h00F0_0000); req(32'h00EF_FFFF);
        // R11: overlapping low area takes precedence
        phase = "R11";
        cfg(5'd20, 24'h30_0000, 24'h18_0000, 0, '0);
        req(32'h0020_0000); req(32'h0018_0000); req(32'h0040_0000); req(32'h00FF_E123);
        // Mixed traffic
        phase = "R3";
        cfg(5'd18, 24'h20_0000, 24'hFF_C000, 0, '0);
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a;
            a = $urandom;
            if (i % 3 == 0) a[23:16] = 8'hFF;
            if (i % 7 == 0) idle(); else req(a);
        end
        idle(); idle();
        finish_run();
    end

endmodule